// File: doc/BRIEF.md
# Store Address and Write Request Generator

This block turns one store-class instruction of a 32-bit core with 16-bit instruction words into a registered memory write request. The register file reads the operands named by the instruction and presents them on dedicated inputs: the Ri and Rj values, the three base registers R13, R14 and R15, one special-register value and the processor status word. When `issue` is high, the block decodes the instruction and selects a base register. It scales the offset field where the mode calls for it, forms the effective address, and places the store data on the big-endian byte lanes with matching lane enables.

The push forms decrement the stack pointer by four and store one word at the decremented address. They also return the new stack pointer on a writeback port with its own strobe. Encodings that the block does not recognise raise `illegal` and produce no request. All results are registered and appear one cycle after the issue. The block has no path to the condition flags, so a store cannot alter them.

Top module: `sts_store_gen`

## Requirements
- R1: Opcode byte instr[15:8] = 0x14, 0x15 or 0x16 stores Ri to address Rj, with size word, half-word or byte respectively. Size codes on `req_size` are 0 = byte, 1 = half, 2 = word. Rj is named by instr[7:4] and Ri by instr[3:0].
- R2: Opcode byte 0x10, 0x11 or 0x12 stores Ri to address R13 + Rj, with size word, half or byte respectively.
- R3: Leading nibble instr[15:12] = 0x3, 0x5 or 0x7 stores Ri to R14 plus the signed 8-bit field instr[11:4]. The field is shifted left by 2 for a word (0x3), by 1 for a half (0x5) and by 0 for a byte (0x7).
- R4: Opcode byte 0x13 stores the word Ri to R15 plus the unsigned 4-bit field instr[7:4] shifted left by 2.
- R5: Opcode byte 0x17 is a push to address R15 - 4 and is always a word access. instr[7:4] = 0 stores Ri, 8 stores the special-register value, and 9 stores the status word. In the same cycle `sp_wr_valid` is high and `sp_wr_data` equals R15 - 4. No other instruction raises `sp_wr_valid`.
- R6: Byte enables are big-endian: `req_be[3]` is the lane at address offset 0. A word enables 4'b1111. A half enables 4'b1100 when addr[1] = 0 and 4'b0011 when addr[1] = 1. A byte enables only the lane given by addr[1:0] (0 gives 4'b1000, 3 gives 4'b0001).
- R7: Write data is placed on lanes matching the enables. A word is passed unchanged, a half is the low 16 bits repeated twice, and a byte is the low 8 bits repeated four times.
- R8: Any other encoding sets `illegal` and raises neither `req_valid` nor `sp_wr_valid`. This covers a leading nibble other than 0x1, 0x3, 0x5 or 0x7, opcode bytes 0x18 to 0x1F, a push selector other than 0, 8 or 9, and a special-register index instr[3:0] above 5.
- R9: Results are registered one cycle after `issue`. In a cycle following no issue, `req_valid`, `sp_wr_valid` and `illegal` are low, and reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 16 | Store instruction word |
| ri_val | input | 32 | Value of register Ri |
| rj_val | input | 32 | Value of register Rj |
| r13_val | input | 32 | Value of R13 (index base) |
| r14_val | input | 32 | Value of R14 (frame base) |
| r15_val | input | 32 | Value of R15 (stack pointer) |
| spc_val | input | 32 | Special register selected by instr[3:0] |
| psw_val | input | 32 | Processor status word |
| req_valid | output | 1 | Write request valid |
| req_addr | output | 32 | Effective byte address |
| req_wdata | output | 32 | Write data on big-endian lanes |
| req_size | output | 2 | 0 byte, 1 half, 2 word |
| req_be | output | 4 | Lane enables, bit 3 = offset 0 |
| sp_wr_valid | output | 1 | Stack-pointer writeback strobe |
| sp_wr_data | output | 32 | New stack pointer |
| illegal | output | 1 | Unrecognised encoding |

## Verification
Every result of this block, including the request, the lane enables, the writeback strobe and the illegal flag, is due exactly one clock edge after the cycle in which `issue` is sampled high. The bench drives each instruction on a falling edge and drops `issue` on the next falling edge. It then reads all outputs at that point, after the single capturing rising edge. A second read one cycle later confirms that the strobes have fallen back, so results can neither arrive late nor persist.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;
    localparam int AB    = $clog2(LANES);
    localparam int SPC_COUNT = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        M_IND, M_IDX, M_FRAME, M_STK, M_PUSH
    } mode_e;

    typedef enum logic [1:0] {
        SRC_RI, SRC_SPC, SRC_PSW
    } src_e;

    typedef struct packed {
        logic       legal;
        mode_e      mode;
        size_e      size;
        src_e       src;
        logic [7:0] off;
    } dec_t;

    function automatic logic [XLEN-1:0] scale_off(mode_e m, size_e s, logic [7:0] f);
        logic [XLEN-1:0] ext;
        if (m == M_STK) begin
            ext = {{(XLEN-4){1'b0}}, f[3:0]};
            return ext << 2;
        end
        ext = {{(XLEN-8){f[7]}}, f};
        case (s)
            SZ_WORD: return ext << 2;
            SZ_HALF: return ext << 1;
            default: return ext;
        endcase
    endfunction
endpackage

// File: rtl/sts_decode.sv
module sts_decode
    import sts_pkg::*;
(
    input  logic [15:0] instr,
    output dec_t        dec
);
    logic [7:0] op;
    logic [3:0] sub;
    logic [3:0] rsel;

    assign op   = instr[15:8];
    assign sub  = instr[7:4];
    assign rsel = instr[3:0];

    always_comb begin
        dec       = '0;
        dec.mode  = M_IND;
        dec.size  = SZ_WORD;
        dec.src   = SRC_RI;
        dec.off   = {4'b0, sub};
        case (op[7:4])
            4'h1: begin
                dec.legal = 1'b1;
                case (op[3:0])
                    4'h0: begin dec.mode = M_IDX; dec.size = SZ_WORD; end
                    4'h1: begin dec.mode = M_IDX; dec.size = SZ_HALF; end
                    4'h2: begin dec.mode = M_IDX; dec.size = SZ_BYTE; end
                    4'h3: begin dec.mode = M_STK; dec.size = SZ_WORD; end
                    4'h4: begin dec.mode = M_IND; dec.size = SZ_WORD; end
                    4'h5: begin dec.mode = M_IND; dec.size = SZ_HALF; end
                    4'h6: begin dec.mode = M_IND; dec.size = SZ_BYTE; end
                    4'h7: begin
                        dec.mode = M_PUSH;
                        dec.size = SZ_WORD;
                        case (sub)
                            4'h0: dec.src = SRC_RI;
                            4'h8: begin
                                dec.src   = SRC_SPC;
                                dec.legal = (int'(rsel) < SPC_COUNT);
                            end
                            4'h9: dec.src = SRC_PSW;
                            default: dec.legal = 1'b0;
                        endcase
                    end
                    default: dec.legal = 1'b0;
                endcase
            end
            4'h3: begin dec.legal = 1'b1; dec.mode = M_FRAME; dec.size = SZ_WORD; dec.off = instr[11:4]; end
            4'h5: begin dec.legal = 1'b1; dec.mode = M_FRAME; dec.size = SZ_HALF; dec.off = instr[11:4]; end
            4'h7: begin dec.legal = 1'b1; dec.mode = M_FRAME; dec.size = SZ_BYTE; dec.off = instr[11:4]; end
            default: dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sts_agu.sv
module sts_agu
    import sts_pkg::*;
(
    input  dec_t            dec,
    input  logic [XLEN-1:0] ri_val,
    input  logic [XLEN-1:0] rj_val,
    input  logic [XLEN-1:0] r13_val,
    input  logic [XLEN-1:0] r14_val,
    input  logic [XLEN-1:0] r15_val,
    input  logic [XLEN-1:0] spc_val,
    input  logic [XLEN-1:0] psw_val,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] data,
    output logic [XLEN-1:0] sp_next
);
    localparam logic [XLEN-1:0] PUSH_STEP = XLEN'(LANES);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] disp;

    assign sp_next = r15_val - PUSH_STEP;

    always_comb begin
        base = rj_val;
        disp = '0;
        case (dec.mode)
            M_IND:   base = rj_val;
            M_IDX:   begin base = r13_val; disp = rj_val; end
            M_FRAME: begin base = r14_val; disp = scale_off(dec.mode, dec.size, dec.off); end
            M_STK:   begin base = r15_val; disp = scale_off(dec.mode, dec.size, dec.off); end
            M_PUSH:  base = sp_next;
            default: base = rj_val;
        endcase
        addr = base + disp;
    end

    always_comb begin
        case (dec.src)
            SRC_SPC: data = spc_val;
            SRC_PSW: data = psw_val;
            default: data = ri_val;
        endcase
    end
endmodule

// File: rtl/sts_lanes.sv
module sts_lanes
    import sts_pkg::*;
(
    input  size_e           size,
    input  logic [AB-1:0]   alow,
    input  logic [XLEN-1:0] data,
    output logic [LANES-1:0] be,
    output logic [XLEN-1:0] wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [AB-1:0] LIDX = AB'(g);
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    be[LANES-1-g] = (alow == LIDX);
                    wdata[XLEN-1-8*g -: 8] = data[7:0];
                end
                SZ_HALF: begin
                    be[LANES-1-g] = (alow[AB-1:1] == LIDX[AB-1:1]);
                    wdata[XLEN-1-8*g -: 8] = LIDX[0] ? data[7:0] : data[15:8];
                end
                default: begin
                    be[LANES-1-g] = 1'b1;
                    wdata[XLEN-1-8*g -: 8] = data[XLEN-1-8*g -: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/sts_store_gen.sv
module sts_store_gen
    import sts_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue,
    input  logic [15:0] instr,
    input  logic [31:0] ri_val,
    input  logic [31:0] rj_val,
    input  logic [31:0] r13_val,
    input  logic [31:0] r14_val,
    input  logic [31:0] r15_val,
    input  logic [31:0] spc_val,
    input  logic [31:0] psw_val,
    output logic        req_valid,
    output logic [31:0] req_addr,
    output logic [31:0] req_wdata,
    output logic [1:0]  req_size,
    output logic [3:0]  req_be,
    output logic        sp_wr_valid,
    output logic [31:0] sp_wr_data,
    output logic        illegal
);
    dec_t            dec;
    logic [XLEN-1:0] addr_c, data_c, sp_c, wdata_c;
    logic [LANES-1:0] be_c;

    sts_decode u_dec (.instr(instr), .dec(dec));

    sts_agu u_agu (
        .dec(dec), .ri_val(ri_val), .rj_val(rj_val), .r13_val(r13_val),
        .r14_val(r14_val), .r15_val(r15_val), .spc_val(spc_val),
        .psw_val(psw_val), .addr(addr_c), .data(data_c), .sp_next(sp_c)
    );

    sts_lanes u_lanes (
        .size(dec.size), .alow(addr_c[AB-1:0]), .data(data_c),
        .be(be_c), .wdata(wdata_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid   <= 1'b0;
            sp_wr_valid <= 1'b0;
            illegal     <= 1'b0;
            req_addr    <= '0;
            req_wdata   <= '0;
            req_size    <= '0;
            req_be      <= '0;
            sp_wr_data  <= '0;
        end else begin
            req_valid   <= issue && dec.legal;
            sp_wr_valid <= issue && dec.legal && (dec.mode == M_PUSH);
            illegal     <= issue && !dec.legal;
            if (issue && dec.legal) begin
                req_addr   <= addr_c;
                req_wdata  <= wdata_c;
                req_size   <= dec.size;
                req_be     <= be_c;
                sp_wr_data <= sp_c;
            end
        end
    end
endmodule

// File: rtl/sts_store_gen_chk.sv
module sts_store_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        issue,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic [3:0]  req_be,
    input logic        sp_wr_valid,
    input logic [31:0] sp_wr_data,
    input logic        illegal
);
    assert_push_sp_R5: assert property (@(posedge clk) disable iff (rst)
        sp_wr_valid |-> (req_valid && req_addr == sp_wr_data && req_size == 2'd2));

    assert_word_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd2) |-> req_be == 4'hF);

    assert_half_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd1) |-> (req_be == {~req_addr[1], ~req_addr[1], req_addr[1], req_addr[1]}));

    assert_byte_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd0) |-> ($countones(req_be) == 1 && req_be[3 - req_addr[1:0]]));

    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!req_valid && !sp_wr_valid));

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        !issue |=> (!req_valid && !illegal && !sp_wr_valid));
endmodule

bind sts_store_gen sts_store_gen_chk u_chk (
    .clk(clk), .rst(rst), .issue(issue), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_be(req_be),
    .sp_wr_valid(sp_wr_valid), .sp_wr_data(sp_wr_data), .illegal(illegal)
);

// File: tb/sts_store_gen_test.sv
module sts_store_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] ri_val = '0, rj_val = '0, r13_val = '0, r14_val = '0;
    logic [31:0] r15_val = '0, spc_val = '0, psw_val = '0;
    logic        req_valid, sp_wr_valid, illegal;
    logic [31:0] req_addr, req_wdata, sp_wr_data;
    logic [1:0]  req_size;
    logic [3:0]  req_be;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sts_store_gen uut (
        .clk(clk), .rst(rst), .issue(issue), .instr(instr),
        .ri_val(ri_val), .rj_val(rj_val), .r13_val(r13_val), .r14_val(r14_val),
        .r15_val(r15_val), .spc_val(spc_val), .psw_val(psw_val),
        .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_size(req_size), .req_be(req_be), .sp_wr_valid(sp_wr_valid),
        .sp_wr_data(sp_wr_data), .illegal(illegal)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic fire(logic [15:0] ins);
        @(negedge clk);
        instr = ins;
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic expect_req(string tag, logic [31:0] a, logic [31:0] d,
                              logic [1:0] s, logic [3:0] be, logic push);
        chk({tag, " valid"}, 32'(req_valid), 32'd1);
        chk({tag, " addr"},  req_addr, a);
        chk({tag, " wdata"}, req_wdata, d);
        chk({tag, " size"},  32'(req_size), 32'(s));
        chk({tag, " be"},    32'(req_be), 32'(be));
        chk({tag, " spwr"},  32'(sp_wr_valid), 32'(push));
        chk({tag, " illegal"}, 32'(illegal), 32'd0);
        if (push) chk({tag, " spdata"}, sp_wr_data, a);
    endtask

    task automatic test_reset();
        chk("R9 reset valid", 32'(req_valid), 32'd0);
        chk("R9 reset spwr", 32'(sp_wr_valid), 32'd0);
        chk("R9 reset illegal", 32'(illegal), 32'd0);
    endtask

    task automatic test_indirect();
        ri_val = 32'hA1B2C3D4;
        rj_val = 32'h0000_2000; fire(16'h1453);
        expect_req("R1 word", 32'h2000, 32'hA1B2C3D4, 2'd2, 4'hF, 1'b0);
        rj_val = 32'h0000_2002; fire(16'h1553);
        expect_req("R1 half R6 R7", 32'h2002, 32'hC3D4C3D4, 2'd1, 4'h3, 1'b0);
        rj_val = 32'h0000_2001; fire(16'h1653);
        expect_req("R1 byte R6 R7", 32'h2001, 32'hD4D4D4D4, 2'd0, 4'h4, 1'b0);
    endtask

    task automatic test_indexed();
        r13_val = 32'h100; rj_val = 32'h24; ri_val = 32'h11223344;
        fire(16'h1053);
        expect_req("R2 word", 32'h124, 32'h11223344, 2'd2, 4'hF, 1'b0);
        rj_val = 32'h20; fire(16'h1153);
        expect_req("R2 half R6", 32'h120, 32'h33443344, 2'd1, 4'hC, 1'b0);
        rj_val = 32'h26; fire(16'h1253);
        expect_req("R2 byte R6", 32'h126, 32'h44444444, 2'd0, 4'h2, 1'b0);
    endtask

    task automatic test_frame();
        r14_val = 32'h1000; ri_val = 32'hCAFEBABE;
        fire(16'h3FF3);
        expect_req("R3 word neg", 32'h0FFC, 32'hCAFEBABE, 2'd2, 4'hF, 1'b0);
        fire(16'h3053);
        expect_req("R3 word pos", 32'h1014, 32'hCAFEBABE, 2'd2, 4'hF, 1'b0);
        fire(16'h5803);
        expect_req("R3 half min", 32'h0F00, 32'hBABEBABE, 2'd1, 4'hC, 1'b0);
        fire(16'h77F3);
        expect_req("R3 byte max R6", 32'h107F, 32'hBEBEBEBE, 2'd0, 4'h1, 1'b0);
    endtask

    task automatic test_stack();
        r15_val = 32'h8000; ri_val = 32'h01020304;
        fire(16'h13F3);
        expect_req("R4 u4 max", 32'h803C, 32'h01020304, 2'd2, 4'hF, 1'b0);
        fire(16'h1303);
        expect_req("R4 zero", 32'h8000, 32'h01020304, 2'd2, 4'hF, 1'b0);
    endtask

    task automatic test_push();
        r15_val = 32'h8000; ri_val = 32'h0BADF00D;
        spc_val = 32'h5A5A0001; psw_val = 32'h000000F1;
        fire(16'h1703);
        expect_req("R5 push ri", 32'h7FFC, 32'h0BADF00D, 2'd2, 4'hF, 1'b1);
        fire(16'h1785);
        expect_req("R5 push spc", 32'h7FFC, 32'h5A5A0001, 2'd2, 4'hF, 1'b1);
        fire(16'h1790);
        expect_req("R5 push psw", 32'h7FFC, 32'h000000F1, 2'd2, 4'hF, 1'b1);
        @(negedge clk);
        chk("R9 strobe drops", 32'(req_valid), 32'd0);
        chk("R5 R9 spwr drops", 32'(sp_wr_valid), 32'd0);
    endtask

    task automatic test_illegal();
        logic [15:0] bad [4] = '{16'h8000, 16'h1800, 16'h1713, 16'h1786};
        foreach (bad[i]) begin
            fire(bad[i]);
            chk($sformatf("R8 illegal %h", bad[i]), 32'(illegal), 32'd1);
            chk($sformatf("R8 no req %h", bad[i]), 32'(req_valid), 32'd0);
            chk($sformatf("R8 no spwr %h", bad[i]), 32'(sp_wr_valid), 32'd0);
        end
        @(negedge clk);
        chk("R9 illegal drops", 32'(illegal), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        test_indirect();
        test_indexed();
        test_frame();
        test_stack();
        test_push();
        test_illegal();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule